// File: doc/BRIEF.md
# Offset-Based Counter CSR Pair

This block puts a readable and writable counter register in front of a free-running 64-bit event counter that software cannot change. It does not hold the count. It holds a 64-bit offset that is split into a low and a high 32-bit half. A read returns the counter plus the offset. A write changes the offset so that later reads continue counting from the written value.

Software sees two 32-bit access ports, one for the low half and one for the high half of the 64-bit view. The high port rebuilds the carry out of the low half, so the two halves together always form one consistent 64-bit value.

A parameter picks one of two write behaviours:
- **Plain:** a write lands on exactly the written value.
- **Performance-counter:** a write lands one below the written value. This allows for the increment that the pipeline applies in the same cycle. On the high port this removes one from the low offset and borrows into the high offset when the low offset was zero.

When the counter is not bound to a source, it counts as zero. The pair then behaves as a plain scratch register.

Top module: `ctr_offset_csr`

## Requirements
- R1: `lo_rd_data` equals the low 32 bits of the effective counter plus the low offset, modulo 2^32. With no write, the difference `lo_rd_data` minus the effective low count stays fixed from cycle to cycle.
- R2: In the plain variant, a low write sets the low offset to the written data minus the effective low count of that cycle. From the next cycle on, `lo_rd_data` equals the written data plus the counter advance since the write.
- R3: While `cnt_bound` is 0, the effective counter is zero whatever `cnt_val` carries. With no write, both read ports then hold their values.
- R4: `hi_rd_data` is bits 63:32 of the 64-bit effective counter plus the 64-bit offset `{high offset, low offset}`.
- R5: In the plain variant, a high write sets the high offset to the written data minus bits 63:32 of the effective counter, minus a carry. The carry is 1 when the effective low count plus the low offset reaches 2^32. From the next cycle the 64-bit view `{hi_rd_data, lo_rd_data}` equals `{written data, previous lo_rd_data}` plus the counter advance.
- R6: In the performance variant, a low write stores a low offset one less than the plain variant would.
- R7: In the performance variant, a high write first computes the high offset as in R5. It then decrements the low offset by one, and also decrements the high offset by one when the low offset was zero before that step. As a result, the next 64-bit view equals `{written data, previous lo_rd_data}` minus 1, plus the counter advance.
- R8: Reset (`rst_n` low, asynchronous) clears both offsets. After reset, the read ports show the raw effective counter.
- R9: A write takes effect at the clock edge. A read in the write cycle still shows the value from before the write.
- R10: When low and high writes fall in the same cycle, the low write is applied first and the high computation uses the updated low offset. The next 64-bit view equals `{hi data, lo data − d}` minus d, plus the counter advance, where d is 0 in the plain variant and 1 in the performance variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 64 | Free-running event counter value |
| cnt_bound | input | 1 | 1 when a counter source is attached; 0 makes the counter read as zero |
| lo_wr_en | input | 1 | Write strobe for the low CSR |
| lo_wr_data | input | 32 | Write data for the low CSR |
| hi_wr_en | input | 1 | Write strobe for the high CSR |
| hi_wr_data | input | 32 | Write data for the high CSR |
| lo_rd_data | output | 32 | Low CSR read value |
| hi_rd_data | output | 32 | High CSR read value |

## Verification
Both read ports are combinational from the present counter and the offset registers. A counter change therefore shows in the same cycle, and a write shows exactly one edge later.

The bench models each variant with two 32-bit offsets. Every high write is treated as setting a 64-bit target value, from which the model derives both offsets. The inputs are driven just after a falling edge, and the outputs are compared one nanosecond later against the model as it stood before that cycle's edge. The model is advanced only after the rising edge, so the value seen in the write cycle and the value seen in the cycle after it are both checked.

// File: rtl/ctr_ofs_pkg.sv
package ctr_ofs_pkg;

  localparam int unsigned DEF_HALF_W = 32;

  typedef enum logic {
    VAR_PLAIN = 1'b0,
    VAR_PERF  = 1'b1
  } ctr_variant_e;

endpackage

// File: rtl/ctr_ofs_view.sv
module ctr_ofs_view #(
  parameter int unsigned HALF_W = ctr_ofs_pkg::DEF_HALF_W,
  localparam int unsigned FULL_W = 2 * HALF_W
) (
  input  logic [FULL_W-1:0] cnt_val,
  input  logic              cnt_bound,
  input  logic [HALF_W-1:0] off_lo_q,
  input  logic [HALF_W-1:0] off_hi_q,
  output logic [FULL_W-1:0] eff_cnt,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi
);

  logic [FULL_W-1:0] sum_full;

  // An unbound counter is seen as zero
  always_comb begin
    eff_cnt  = cnt_bound ? cnt_val : '0;
    sum_full = eff_cnt + {off_hi_q, off_lo_q};
    rd_lo    = sum_full[HALF_W-1:0];
    rd_hi    = sum_full[FULL_W-1:HALF_W];
  end

endmodule

// File: rtl/ctr_ofs_lo_upd.sv
module ctr_ofs_lo_upd
  import ctr_ofs_pkg::*;
#(
  parameter int unsigned  HALF_W  = DEF_HALF_W,
  parameter ctr_variant_e VARIANT = VAR_PLAIN
) (
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [HALF_W-1:0] eff_lo,
  input  logic [HALF_W-1:0] off_lo_q,
  output logic [HALF_W-1:0] off_lo_mid
);

  logic [HALF_W-1:0] adjust;

  generate
    if (VARIANT == VAR_PERF) begin : g_perf
      assign adjust = HALF_W'(1);
    end else begin : g_plain
      assign adjust = '0;
    end
  endgenerate

  always_comb begin
    off_lo_mid = off_lo_q;
    if (wr_en) begin
      off_lo_mid = wr_data - eff_lo - adjust;
    end
  end

endmodule

// File: rtl/ctr_ofs_hi_upd.sv
module ctr_ofs_hi_upd
  import ctr_ofs_pkg::*;
#(
  parameter int unsigned  HALF_W  = DEF_HALF_W,
  parameter ctr_variant_e VARIANT = VAR_PLAIN,
  localparam int unsigned FULL_W  = 2 * HALF_W
) (
  input  logic              wr_en,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [FULL_W-1:0] eff_cnt,
  input  logic [HALF_W-1:0] off_lo_mid,
  input  logic [HALF_W-1:0] off_hi_q,
  output logic [HALF_W-1:0] off_lo_nxt,
  output logic [HALF_W-1:0] off_hi_nxt
);

  logic [HALF_W:0]   lo_sum;
  logic              lo_carry;
  logic [HALF_W-1:0] hi_base;
  logic              borrow;

  always_comb begin
    lo_sum   = {1'b0, eff_cnt[HALF_W-1:0]} + {1'b0, off_lo_mid};
    lo_carry = lo_sum[HALF_W];
    hi_base  = wr_data - eff_cnt[FULL_W-1:HALF_W] - HALF_W'(lo_carry);
  end

  generate
    if (VARIANT == VAR_PERF) begin : g_perf
      always_comb begin
        borrow     = (off_lo_mid == '0);
        off_lo_nxt = wr_en ? (off_lo_mid - HALF_W'(1)) : off_lo_mid;
        off_hi_nxt = wr_en ? (hi_base - HALF_W'(borrow)) : off_hi_q;
      end
    end else begin : g_plain
      always_comb begin
        borrow     = 1'b0;
        off_lo_nxt = off_lo_mid;
        off_hi_nxt = wr_en ? hi_base : off_hi_q;
      end
    end
  endgenerate

endmodule

// File: rtl/ctr_offset_csr.sv
module ctr_offset_csr
  import ctr_ofs_pkg::*;
#(
  parameter int unsigned  HALF_W  = DEF_HALF_W,
  parameter ctr_variant_e VARIANT = VAR_PLAIN,
  localparam int unsigned FULL_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FULL_W-1:0] cnt_val,
  input  logic              cnt_bound,
  input  logic              lo_wr_en,
  input  logic [HALF_W-1:0] lo_wr_data,
  input  logic              hi_wr_en,
  input  logic [HALF_W-1:0] hi_wr_data,
  output logic [HALF_W-1:0] lo_rd_data,
  output logic [HALF_W-1:0] hi_rd_data
);

  logic [HALF_W-1:0] off_lo_q, off_hi_q;
  logic [HALF_W-1:0] off_lo_mid, off_lo_nxt, off_hi_nxt;
  logic [FULL_W-1:0] eff_cnt;
  logic              off_en;

  ctr_ofs_view #(.HALF_W(HALF_W)) u_view (
    .cnt_val  (cnt_val),
    .cnt_bound(cnt_bound),
    .off_lo_q (off_lo_q),
    .off_hi_q (off_hi_q),
    .eff_cnt  (eff_cnt),
    .rd_lo    (lo_rd_data),
    .rd_hi    (hi_rd_data)
  );

  // Low write first; the high path sees its result
  ctr_ofs_lo_upd #(.HALF_W(HALF_W), .VARIANT(VARIANT)) u_lo_upd (
    .wr_en     (lo_wr_en),
    .wr_data   (lo_wr_data),
    .eff_lo    (eff_cnt[HALF_W-1:0]),
    .off_lo_q  (off_lo_q),
    .off_lo_mid(off_lo_mid)
  );

  ctr_ofs_hi_upd #(.HALF_W(HALF_W), .VARIANT(VARIANT)) u_hi_upd (
    .wr_en     (hi_wr_en),
    .wr_data   (hi_wr_data),
    .eff_cnt   (eff_cnt),
    .off_lo_mid(off_lo_mid),
    .off_hi_q  (off_hi_q),
    .off_lo_nxt(off_lo_nxt),
    .off_hi_nxt(off_hi_nxt)
  );

  always_comb begin
    off_en = lo_wr_en | hi_wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_lo_q <= '0;
      off_hi_q <= '0;
    end else if (off_en) begin
      off_lo_q <= off_lo_nxt;
      off_hi_q <= off_hi_nxt;
    end
  end

endmodule

// File: rtl/ctr_offset_csr_chk.sv
module ctr_offset_csr_chk
  import ctr_ofs_pkg::*;
#(
  parameter int unsigned  HALF_W  = DEF_HALF_W,
  parameter ctr_variant_e VARIANT = VAR_PLAIN,
  localparam int unsigned FULL_W  = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FULL_W-1:0] cnt_val,
  input logic              cnt_bound,
  input logic              lo_wr_en,
  input logic [HALF_W-1:0] lo_wr_data,
  input logic              hi_wr_en,
  input logic [HALF_W-1:0] hi_wr_data,
  input logic [HALF_W-1:0] lo_rd_data,
  input logic [HALF_W-1:0] hi_rd_data
);

  localparam logic [HALF_W-1:0] D_LO = (VARIANT == VAR_PERF) ? HALF_W'(1) : '0;
  localparam logic [FULL_W-1:0] D_FU = (VARIANT == VAR_PERF) ? FULL_W'(1) : '0;

  logic [FULL_W-1:0] eff;
  logic [HALF_W-1:0] lo_rel;
  logic [FULL_W-1:0] full_rel;

  always_comb begin
    eff      = cnt_bound ? cnt_val : '0;
    lo_rel   = lo_rd_data - eff[HALF_W-1:0];
    full_rel = {hi_rd_data, lo_rd_data} - eff;
  end

  assert_lo_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lo_wr_en) && !$past(hi_wr_en)) |-> (lo_rel == $past(lo_rel)));

  assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lo_wr_en) && !$past(hi_wr_en)) |->
      (lo_rel == $past(lo_wr_data) - $past(eff[HALF_W-1:0]) - D_LO));

  assert_unbound_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !cnt_bound && !$past(cnt_bound) && !$past(lo_wr_en) && !$past(hi_wr_en))
      |-> ($stable(lo_rd_data) && $stable(hi_rd_data)));

  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lo_wr_en) && !$past(hi_wr_en)) |-> (full_rel == $past(full_rel)));

  // R5 in the plain variant, R7 in the performance variant
  assert_hi_write_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hi_wr_en) && !$past(lo_wr_en)) |->
      (full_rel == {$past(hi_wr_data), $past(lo_rd_data)} - D_FU - $past(eff)));

  assert_both_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hi_wr_en) && $past(lo_wr_en)) |->
      (full_rel == {$past(hi_wr_data), $past(lo_wr_data) - D_LO} - D_FU - $past(eff)));

endmodule

bind ctr_offset_csr ctr_offset_csr_chk #(.HALF_W(HALF_W), .VARIANT(VARIANT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_val   (cnt_val),
  .cnt_bound (cnt_bound),
  .lo_wr_en  (lo_wr_en),
  .lo_wr_data(lo_wr_data),
  .hi_wr_en  (hi_wr_en),
  .hi_wr_data(hi_wr_data),
  .lo_rd_data(lo_rd_data),
  .hi_rd_data(hi_rd_data)
);

// File: tb/tb_ctr_offset_csr.sv
`timescale 1ns/1ps
module tb_ctr_offset_csr;
  import ctr_ofs_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt_val;
  logic        cnt_bound;
  logic        lo_wr_en, hi_wr_en;
  logic [31:0] lo_wr_data, hi_wr_data;
  logic [31:0] lo_rd [2];
  logic [31:0] hi_rd [2];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Model state: two 32-bit offsets per variant (index 0 plain, 1 perf)
  logic [31:0] m_lo [2];
  logic [31:0] m_hi [2];

  always #2.5 clk = ~clk;

  ctr_offset_csr #(.VARIANT(VAR_PLAIN)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_bound(cnt_bound),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_rd_data(lo_rd[0]), .hi_rd_data(hi_rd[0])
  );

  ctr_offset_csr #(.VARIANT(VAR_PERF)) dut_perf (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_bound(cnt_bound),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .lo_rd_data(lo_rd[1]), .hi_rd_data(hi_rd[1])
  );

  function automatic logic [63:0] eff_now();
    return cnt_bound ? cnt_val : 64'd0;
  endfunction

  function automatic logic [63:0] model_view(int v);
    return eff_now() + {m_hi[v], m_lo[v]};
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // Model update at the edge: low write first, then a high write seen as
  // setting the 64-bit view to {data, current low view} minus the adjust.
  task automatic model_edge();
    logic [63:0] e, target, off;
    e = eff_now();
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin m_lo[v] = '0; m_hi[v] = '0; end
      return;
    end
    for (int v = 0; v < 2; v++) begin
      if (lo_wr_en) m_lo[v] = lo_wr_data - e[31:0] - 32'(v);
      if (hi_wr_en) begin
        target = {hi_wr_data, e[31:0] + m_lo[v]} - 64'(v);
        off    = target - e;
        m_lo[v] = off[31:0];
        m_hi[v] = off[63:32];
      end
    end
  endtask

  task automatic step(logic [63:0] c, logic b, logic lwe, logic [31:0] lwd,
                      logic hwe, logic [31:0] hwd, string tag);
    logic [63:0] mv;
    cnt_val = c; cnt_bound = b;
    lo_wr_en = lwe; lo_wr_data = lwd; hi_wr_en = hwe; hi_wr_data = hwd;
    #1;
    for (int v = 0; v < 2; v++) begin
      mv = model_view(v);
      check32(tag, v == 0 ? "plain lo" : "perf lo", lo_rd[v], mv[31:0]);
      check32(tag, v == 0 ? "plain hi" : "perf hi", hi_rd[v], mv[63:32]);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    logic [63:0] c;
    for (int v = 0; v < 2; v++) begin m_lo[v] = '0; m_hi[v] = '0; end
    rst_n = 1'b0; cnt_val = 64'h0000_0003_0000_0010; cnt_bound = 1'b1;
    lo_wr_en = 1'b0; hi_wr_en = 1'b0; lo_wr_data = '0; hi_wr_data = '0;
    repeat (3) @(negedge clk);
    step(64'h0000_0003_0000_0010, 1'b1, 0, 0, 0, 0, "R8 reset");
    rst_n = 1'b1;
    // R8: raw counter after reset, counter moving
    c = 64'h0000_0003_0000_0010;
    for (int i = 0; i < 4; i++) begin c += 64'd1; step(c, 1'b1, 0, 0, 0, 0, "R8 R1 R4 raw"); end
    // R7: perf high write with low offset still zero (borrow case)
    c += 64'd1; step(c, 1'b1, 0, 0, 1, 32'h0000_1234, "R7 R5 hi write zero-lo");
    for (int i = 0; i < 3; i++) begin c += 64'd1; step(c, 1'b1, 0, 0, 0, 0, "R7 R5 R9 after hi"); end
    // R2/R6/R9: low write, then counter advances
    c += 64'd1; step(c, 1'b1, 1, 32'hFFFF_FFF8, 0, 0, "R2 R6 R9 lo write");
    for (int i = 0; i < 12; i++) begin c += 64'd1; step(c, 1'b1, 0, 0, 0, 0, "R1 R4 carry into hi"); end
    // R5: high write while low view is past the wrap (carry set)
    c += 64'd1; step(c, 1'b1, 0, 0, 1, 32'hABCD_0000, "R5 R7 hi write carry");
    for (int i = 0; i < 3; i++) begin c += 64'd1; step(c, 1'b1, 0, 0, 0, 0, "R4 R5 R7 after carry"); end
    // Counter near its own low wrap
    c = 64'h0000_0007_FFFF_FFFD;
    step(c, 1'b1, 0, 0, 0, 0, "R1 R4 jump");
    c = 64'h0000_0008_0000_0002;
    step(c, 1'b1, 0, 0, 1, 32'h0000_0042, "R5 R7 hi write wrap");
    step(c + 64'd7, 1'b1, 0, 0, 0, 0, "R4 R5 R7 after wrap");
    // R10: simultaneous writes
    c += 64'd9;
    step(c, 1'b1, 1, 32'h0000_0000, 1, 32'h5555_AAAA, "R10 both writes");
    for (int i = 0; i < 3; i++) begin c += 64'd3; step(c, 1'b1, 0, 0, 0, 0, "R10 R1 after both"); end
    c += 64'd1;
    step(c, 1'b1, 1, 32'h8000_0001, 1, 32'hFFFF_FFFF, "R10 both writes 2");
    c += 64'd1; step(c, 1'b1, 0, 0, 0, 0, "R10 after both 2");
    // R3: unbound counter, scratch behaviour
    step(64'hDEAD_BEEF_0123_4567, 1'b0, 0, 0, 0, 0, "R3 unbound");
    step(64'h1111_2222_3333_4444, 1'b0, 1, 32'h0BAD_F00D, 0, 0, "R3 R2 R6 unbound lo write");
    step(64'h9999_8888_7777_6666, 1'b0, 0, 0, 1, 32'h0000_CAFE, "R3 R5 R7 unbound hi write");
    for (int i = 0; i < 4; i++) step(64'(i) * 64'h0123_4567_89AB_CDEF, 1'b0, 0, 0, 0, 0, "R3 unbound hold");
    // Rebind and mixed random traffic
    for (int i = 0; i < 200; i++) begin
      logic [31:0] r;
      r = $urandom;
      c += 64'(r[3:0]);
      if (r[7:4] == 4'd0) c += {32'd0, $urandom};
      step(c, 1'b1, r[8] & r[9], $urandom, r[10] & r[11], $urandom, "R1 R2 R4 R5 R6 R7 R10 mixed");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule